// File: doc/BRIEF.md
# Dual-Bank Card Data Transmit Buffer

This block holds outgoing data bytes for the data line of a memory card. Storage is split into two banks of eight bytes. The serializer drains the banks in turn while the host refills the other one, so data keeps flowing without a large buffer. The host writes every byte through one write port. A write pointer runs through both banks and wraps from the end of the second bank back to the start of the first. Before a transfer, the host can therefore load all sixteen bytes with sixteen back-to-back writes.

A start pulse arms the transmitter. From then on, each byte request from the serializer gets the next stored byte one cycle later, provided the bank under the read pointer is fully loaded. When the last byte of a bank leaves, that bank's empty flag sets. The host then writes exactly eight new bytes into it. The two empty flags have separate mask bits, and a single interrupt output goes high while any unmasked flag is set. CRC generation, command handling and serial line timing belong to other blocks.

Top module: `card_tx_bank_buffer`

## Requirements
- R1: After a synchronous reset, ser_valid, irq and both bits of bank_empty are 0, no byte can be read, and both banks take writes.
- R2: Accepted writes fill storage in order: bank 0 index 0 to 7, then bank 1 index 0 to 7, then back to bank 0. Bytes leave in the same order they were written.
- R3: A write to a bank that is fully loaded and not yet drained is ignored. It changes neither the stored data nor the write position.
- R4: Until a start pulse has been seen, byte requests are not answered: ser_valid stays 0.
- R5: A ser_req that is accepted produces ser_valid=1 with the byte on ser_data in the following cycle. A request while the bank under the read pointer is not fully loaded produces no ser_valid.
- R6: bank_empty[b] (bit 0 is bank 0) goes high in the same cycle that ser_valid carries the eighth byte of bank b.
- R7: bank_empty[b] clears on a flag_clr[b] pulse or on an accepted write to index 0 of bank b. If it is set and cleared in the same cycle, the set wins.
- R8: irq is the OR over both banks of bank_empty AND NOT irq_mask. It is registered, so it changes in the same cycle as the flag, and one cycle after a mask change.
- R9: While irq_mask[b] is 1, bank_empty[b] cannot raise irq.
- R10: After a bank is drained, exactly eight writes make it readable again, and the read side keeps alternating bank 0, bank 1, bank 0.
- R11: A reset in the middle of operation disarms the transmitter and discards all loaded data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| start | input | 1 | Transmit arm pulse |
| ser_req | input | 1 | Serializer asks for the next byte |
| ser_valid | output | 1 | Byte on ser_data is valid (registered) |
| ser_data | output | 8 | Byte to serializer |
| flag_clr | input | 2 | Per-bank empty flag clear pulse (host read) |
| irq_mask | input | 2 | Per-bank interrupt mask, 1 blocks the flag |
| bank_empty | output | 2 | Per-bank drained flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host writes no more than eight bytes into a freed bank before it is drained again. They also assume that a bank's index 0 write comes before its index 7 write, which the wrapping pointer guarantees. Under these conditions an empty flag and a full bank never coexist. The mask property assumes that the mask holds steady for one cycle before irq is inspected. The directed tasks change the mask only at the falling edge and only between checks. They refill only banks that have actually emptied, with the single deliberate extra write used to show that writes to a full bank are discarded.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int NUM_BANKS = 2;
  typedef logic [NUM_BANKS-1:0] bank_vec_t;
endpackage

// File: rtl/txbuf_mem.sv
module txbuf_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/txbuf_wptr.sv
module txbuf_wptr
  import txbuf_pkg::*;
#(
  parameter int BANK_DEPTH = 8,
  localparam int IDX_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  bank_vec_t         bank_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_go,
  output bank_vec_t         fill_done,
  output bank_vec_t         first_wr
);
  logic             wbank;
  logic [IDX_W-1:0] widx;

  assign wbank = wr_addr[ADDR_W-1];
  assign widx  = wr_addr[IDX_W-1:0];
  assign wr_go = wr_en && !bank_ready[wbank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign fill_done[b] = wr_go && (wbank == 1'(b)) && (widx == IDX_W'(BANK_DEPTH-1));
    assign first_wr[b]  = wr_go && (wbank == 1'(b)) && (widx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)        wr_addr <= '0;
    else if (wr_go) wr_addr <= wr_addr + 1'b1;
  end

  // R2: each accepted write moves the pointer by exactly one, wrapping
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));
  // R3: a refused write leaves the pointer where it was
  a_r3_hold_on_refuse: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> $stable(wr_addr));
endmodule

// File: rtl/txbuf_rptr.sv
module txbuf_rptr
  import txbuf_pkg::*;
#(
  parameter int BANK_DEPTH = 8,
  localparam int IDX_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ser_req,
  input  bank_vec_t         bank_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_go,
  output bank_vec_t         drained,
  output logic              ser_valid
);
  logic             active;
  logic             rbank;
  logic [IDX_W-1:0] ridx;

  assign rbank = rd_addr[ADDR_W-1];
  assign ridx  = rd_addr[IDX_W-1:0];
  assign rd_go = ser_req && active && bank_ready[rbank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign drained[b] = rd_go && (rbank == 1'(b)) && (ridx == IDX_W'(BANK_DEPTH-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      rd_addr   <= '0;
      ser_valid <= 1'b0;
    end else begin
      if (start) active <= 1'b1;
      if (rd_go) rd_addr <= rd_addr + 1'b1;
      ser_valid <= rd_go;
    end
  end

  // R5: a valid byte always answers a request of the previous cycle
  a_r5_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    ser_valid |-> $past(ser_req));
  // R4: nothing leaves before the transmitter is armed
  a_r4_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ser_valid);
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags
  import txbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bank_vec_t fill_done,
  input  bank_vec_t drained,
  input  bank_vec_t first_wr,
  input  bank_vec_t flag_clr,
  input  bank_vec_t irq_mask,
  output bank_vec_t bank_ready,
  output bank_vec_t bank_empty,
  output logic      irq
);
  bank_vec_t empty_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      empty_d[b] = bank_empty[b];
      if (flag_clr[b] || first_wr[b]) empty_d[b] = 1'b0;
      if (drained[b])                 empty_d[b] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)               bank_ready[b] <= 1'b0;
      else if (fill_done[b]) bank_ready[b] <= 1'b1;
      else if (drained[b])   bank_ready[b] <= 1'b0;
    end

    // R6: a drained bank flags empty on the next edge
    a_r6_flag_on_drain: assert property (@(posedge clk) disable iff (rst)
      drained[b] |=> bank_empty[b]);
    // R10: an empty bank is never also marked loaded
    a_r10_empty_not_ready: assert property (@(posedge clk) disable iff (rst)
      bank_empty[b] |-> !bank_ready[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_empty <= '0;
      irq        <= 1'b0;
    end else begin
      bank_empty <= empty_d;
      irq        <= |(empty_d & ~irq_mask);
    end
  end

  // R9: fully masked and steady mask keeps the interrupt low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '1) && $stable(irq_mask) |-> !irq);
endmodule

// File: rtl/card_tx_bank_buffer.sv
module card_tx_bank_buffer
  import txbuf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic              ser_req,
  output logic              ser_valid,
  output logic [DATA_W-1:0] ser_data,
  input  logic [1:0]        flag_clr,
  input  logic [1:0]        irq_mask,
  output logic [1:0]        bank_empty,
  output logic              irq
);
  localparam int IDX_W  = $clog2(BANK_DEPTH);
  localparam int ADDR_W = IDX_W + 1;

  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_go, rd_go;
  bank_vec_t         bank_ready, fill_done, first_wr, drained;

  txbuf_wptr #(.BANK_DEPTH(BANK_DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bank_ready(bank_ready),
    .wr_addr(wr_addr), .wr_go(wr_go), .fill_done(fill_done), .first_wr(first_wr)
  );

  txbuf_rptr #(.BANK_DEPTH(BANK_DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .start(start), .ser_req(ser_req),
    .bank_ready(bank_ready), .rd_addr(rd_addr), .rd_go(rd_go),
    .drained(drained), .ser_valid(ser_valid)
  );

  txbuf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_go), .raddr(rd_addr), .rdata(ser_data)
  );

  txbuf_flags u_flags (
    .clk(clk), .rst(rst), .fill_done(fill_done), .drained(drained),
    .first_wr(first_wr), .flag_clr(flag_clr), .irq_mask(irq_mask),
    .bank_ready(bank_ready), .bank_empty(bank_empty), .irq(irq)
  );

  // R8: an unmasked set flag with a steady mask must show on irq
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    ((bank_empty & ~irq_mask) != '0) && $stable(irq_mask) |-> irq);
endmodule

// File: tb/card_tx_bank_buffer_test.sv
module card_tx_bank_buffer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       ser_req = 1'b0;
  logic [1:0] flag_clr = '0;
  logic [1:0] irq_mask = '0;
  logic       ser_valid;
  logic [7:0] ser_data;
  logic [1:0] bank_empty;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  card_tx_bank_buffer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .ser_req(ser_req), .ser_valid(ser_valid), .ser_data(ser_data),
    .flag_clr(flag_clr), .irq_mask(irq_mask), .bank_empty(bank_empty), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(output logic v, output logic [7:0] d);
    @(negedge clk); ser_req = 1'b1;
    @(posedge clk); #1; ser_req = 1'b0;
    v = ser_valid; d = ser_data;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic drain(input logic [7:0] base, input int bank, input string req);
    logic v; logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(v, d);
      chk(req, v, 1);
      chk(req, d, base + 8'(i));
      if (i < 7) chk({req, " flag early"}, bank_empty[bank], 0);
    end
    chk({"R6 ", req}, bank_empty[bank], 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 valid", ser_valid, 0);
    chk("R1 empty", bank_empty, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_no_start();
    logic v; logic [7:0] d;
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i));
    rd(v, d);
    chk("R4 req before start", v, 0);
  endtask

  task automatic t_full_ignored();
    wr(8'hEE);
    pulse_start();
  endtask

  task automatic t_drain_bank0();
    drain(8'h10, 0, "R2 bank0");
    chk("R8 irq with flag", irq, 1);
    chk("R6 other flag", bank_empty[1], 0);
    @(negedge clk); flag_clr = 2'b01;
    @(posedge clk); #1; flag_clr = 2'b00;
    chk("R7 clear by read", bank_empty[0], 0);
    chk("R8 irq drops", irq, 0);
  endtask

  task automatic t_masked_bank1();
    logic v; logic [7:0] d;
    @(negedge clk); irq_mask = 2'b11;
    drain(8'h18, 1, "R3 bank1 no overwrite");
    chk("R9 masked irq", irq, 0);
    @(negedge clk); irq_mask = 2'b01;
    @(posedge clk); #1;
    chk("R8 irq after unmask", irq, 1);
    @(negedge clk); irq_mask = 2'b11;
    @(posedge clk); #1;
    chk("R9 remask", irq, 0);
    rd(v, d);
    chk("R5 req on unloaded bank", v, 0);
  endtask

  task automatic t_refill();
    for (int i = 0; i < 8; i++) wr(8'h40 + 8'(i));
    chk("R7 other flag kept", bank_empty[1], 1);
    drain(8'h40, 0, "R10 bank0 again");
    wr(8'h50);
    chk("R7 clear by first write", bank_empty[1], 0);
    chk("R7 bank0 still set", bank_empty[0], 1);
  endtask

  task automatic t_mid_reset();
    logic v; logic [7:0] d;
    for (int i = 1; i < 8; i++) wr(8'h50 + 8'(i));
    do_reset();
    chk("R11 flags", bank_empty, 0);
    chk("R11 irq", irq, 0);
    rd(v, d);
    chk("R11 disarmed", v, 0);
    pulse_start();
    rd(v, d);
    chk("R11 data dropped", v, 0);
    for (int i = 0; i < 8; i++) wr(8'h60 + 8'(i));
    irq_mask = 2'b00;
    drain(8'h60, 0, "R1 writes accepted");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_no_start();
    t_full_ignored();
    t_drain_bank0();
    t_masked_bank1();
    t_refill();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule